// File: doc/BRIEF.md
# Eight-Bank DRAM Command Timing Guard

This block sits beside a DRAM command scheduler and judges every command the scheduler proposes. It keeps per-bank state for eight banks (idle, activating, row open, precharging), together with down-counters for the row-to-column delay, the precharge recovery time, the minimum row-active time and the row cycle time. Each command presented on the input receives a registered verdict one clock later. Only a legal command changes bank state. An illegal command is reported and otherwise discarded.

All timing limits are given as picosecond parameters and turned into clock counts at elaboration, rounding up, for a configurable clock period. Column commands may request auto-precharge. The bank then closes itself once the burst time has elapsed and the active-time minimum is met, and it counts precharge recovery after that. A refresh interval timer raises a sticky refresh request. The interval is halved while the hot-case input is high. An accepted refresh clears the request and starts the interval again.

Top module: `dram_bank_timing_guard`

## Requirements
- R1: While reset is held low at a clock edge, and until the first command, rsp_valid, ref_req and all bank_open bits are 0.
- R2: Every picosecond limit becomes ceil(limit / CLK_PS) clocks. With the defaults this gives row-to-column 4, precharge 4, active-time 11, row cycle 16 and refresh interval 2080.
- R3: Activate (cmd_op 0) is legal only if the bank has no row open, any precharge recovery on it has finished, and row-cycle clocks have passed since that bank's last accepted activate.
- R4: Read (1) and write (2) are legal only on a bank with an open row, at least row-to-column clocks after its activate, and with no auto-precharge pending. Each command with cmd_valid high gets rsp_valid high on the next edge, with rsp_legal giving the verdict.
- R5: Precharge (3) on an open bank is legal once active-time clocks have passed since its activate, and it closes the row. Precharge on a bank with no open row is legal and changes nothing.
- R6: A column command with cmd_ap high closes the row BURST_CLK clocks later, or when the active-time minimum is met if that is later. The bank then counts precharge recovery from the closing edge.
- R7: While an auto-precharge is pending on a bank, read, write and precharge to that bank are illegal.
- R8: An illegal command, including an opcode from 5 to 7, changes no bank state and does not clear the refresh request.
- R9: Banks are independent, and a command to one bank never alters another bank's state or legality.
- R10: Auto-refresh (4) is legal only when every bank is idle with its precharge recovery finished. An accepted refresh clears ref_req and restarts the interval.
- R11: ref_req rises exactly interval clocks after reset or after the last accepted refresh, and stays high until a refresh is accepted.
- R12: While temp_hi is high, the refresh interval is half the normal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | 0 activate, 1 read, 2 write, 3 precharge, 4 auto-refresh |
| cmd_bank | input | 3 | Target bank |
| cmd_ap | input | 1 | Auto-precharge request on read or write |
| temp_hi | input | 1 | Case temperature is above 85 °C |
| rsp_valid | output | 1 | A verdict is present |
| rsp_legal | output | 1 | The command was legal and accepted |
| bank_open | output | 8 | One bit per bank, set while a row is open |
| ref_req | output | 1 | Sticky refresh request |

## Verification
The bench drives each timer to one clock before its limit and then to the limit itself. A design off by one register stage, or rounding down instead of up, accepts a command one cycle early or refuses it one cycle late. It separates the row-cycle limit from active time plus precharge, so a bank that ignored row cycle would reopen a cycle too soon. It also issues auto-precharge both before and after the active-time minimum. A design that closed the row on burst time alone would drop bank_open several cycles early. The bench tries refresh while one bank is still recovering and while rows are open, and it times the request edge in both temperature modes. This catches a request that clears on a refused refresh and an interval that ignores temp_hi.

// File: rtl/dbt_pkg.sv
// Shared types and helpers for the DRAM bank timing guard.
// Assumes all timing parameters are positive picosecond values.
package dbt_pkg;

    typedef enum logic [2:0] {
        OP_ACT = 3'd0,
        OP_RD  = 3'd1,
        OP_WR  = 3'd2,
        OP_PRE = 3'd3,
        OP_REF = 3'd4
    } cmd_op_e;

    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,
        BK_ACT  = 2'd1,
        BK_OPEN = 2'd2,
        BK_PRE  = 2'd3
    } bank_st_e;

    // Convert a picosecond limit to clocks, rounding up, never below one.
    function automatic int ps_to_clk(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dbt_bank.sv
// One bank's state machine and spacing counters.
// Assumes the top only raises a *_go strobe for commands it judged legal
// from this bank's *_ok outputs; every limit is at least one clock.
module dbt_bank
    import dbt_pkg::*;
#(
    parameter int RCD_CLK   = 4,
    parameter int RP_CLK    = 4,
    parameter int RAS_CLK   = 11,
    parameter int RC_CLK    = 16,
    parameter int BURST_CLK = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_go,
    input  logic col_go,
    input  logic col_ap,
    input  logic pre_go,
    output logic act_ok,
    output logic col_ok,
    output logic pre_ok,
    output logic idle_rdy,
    output logic row_open
);
    localparam int MAXC = max2(max2(RCD_CLK, RP_CLK), max2(max2(RAS_CLK, RC_CLK), BURST_CLK));
    localparam int CW   = $clog2(MAXC + 1);

    bank_st_e        st;
    logic [CW-1:0]   rcd_cnt, rp_cnt, ras_cnt, rc_cnt, ap_cnt;
    logic            ap_pend;

    // Derive legality of each command class from state and counters.
    always_comb begin
        row_open = (st == BK_ACT) || (st == BK_OPEN);
        idle_rdy = (st == BK_IDLE) || ((st == BK_PRE) && (rp_cnt == '0));
        act_ok   = idle_rdy && (rc_cnt == '0);
        col_ok   = row_open && (rcd_cnt == '0) && !ap_pend;
        pre_ok   = !row_open || ((ras_cnt == '0) && !ap_pend);
    end

    // Advance counters and state; accepted commands override aging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= BK_IDLE;
            rcd_cnt <= '0;
            rp_cnt  <= '0;
            ras_cnt <= '0;
            rc_cnt  <= '0;
            ap_cnt  <= '0;
            ap_pend <= 1'b0;
        end else begin
            if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
            if (rp_cnt  != '0) rp_cnt  <= rp_cnt  - 1'b1;
            if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
            if (rc_cnt  != '0) rc_cnt  <= rc_cnt  - 1'b1;
            if (ap_cnt  != '0) ap_cnt  <= ap_cnt  - 1'b1;

            if ((st == BK_ACT) && (rcd_cnt == '0)) st <= BK_OPEN;
            if ((st == BK_PRE) && (rp_cnt == '0))  st <= BK_IDLE;
            if (ap_pend && (ap_cnt == '0) && (ras_cnt == '0)) begin
                st      <= BK_PRE;
                rp_cnt  <= CW'(RP_CLK - 1);
                ap_pend <= 1'b0;
            end

            if (act_go) begin
                st      <= BK_ACT;
                rcd_cnt <= CW'(RCD_CLK - 1);
                ras_cnt <= CW'(RAS_CLK - 1);
                rc_cnt  <= CW'(RC_CLK - 1);
            end else if (col_go && col_ap) begin
                ap_pend <= 1'b1;
                ap_cnt  <= CW'(BURST_CLK - 1);
            end else if (pre_go && row_open) begin
                st     <= BK_PRE;
                rp_cnt <= CW'(RP_CLK - 1);
            end
        end
    end

    // R3: an accepted activate leaves the row open on the next cycle.
    a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |=> row_open);
    // R5: an accepted precharge of an open row closes it.
    a_r5_pre_shuts: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_go && row_open) |=> !row_open);
    // R6: auto-precharge cannot close the row before active time is met.
    a_r6_ap_waits_ras: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_pend && (ras_cnt != '0)) |=> row_open);

endmodule

// File: rtl/dbt_refresh.sv
// Refresh interval timer with a sticky request.
// Assumes REFI_CLK >= 2 so the halved interval is at least one clock.
module dbt_refresh #(
    parameter int REFI_CLK = 2080
) (
    input  logic clk,
    input  logic rst_n,
    input  logic temp_hi,
    input  logic ref_go,
    output logic ref_req
);
    localparam int CW = $clog2(REFI_CLK + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic [CW:0]   cnt_nx;

    // Pick the interval for the current temperature range.
    always_comb begin
        limit  = temp_hi ? CW'(REFI_CLK / 2) : CW'(REFI_CLK);
        cnt_nx = {1'b0, cnt} + 1'b1;
    end

    // Count clocks since the last refresh; hold the request until served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            ref_req <= 1'b0;
        end else if (ref_go) begin
            cnt     <= '0;
            ref_req <= 1'b0;
        end else begin
            if (cnt != CW'(REFI_CLK)) cnt <= cnt + 1'b1;
            if (cnt_nx >= {1'b0, limit}) ref_req <= 1'b1;
        end
    end

    // R10: an accepted refresh drops the request.
    a_r10_ref_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ref_go |=> !ref_req);
    // R11: the request stays up until a refresh is accepted.
    a_r11_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_go) |=> ref_req);
    // R12: when hot and past the halved interval, the request is raised.
    a_r12_hot_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_hi && !ref_go && (cnt >= CW'(REFI_CLK / 2))) |=> ref_req);

endmodule

// File: rtl/dram_bank_timing_guard.sv
// Judges DRAM commands against per-bank spacing limits and refresh rules.
// Assumes one command per clock; verdicts appear one clock after the command.
module dram_bank_timing_guard
    import dbt_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int CLK_PS    = 3750,
    parameter int T_RCD_PS  = 12000,
    parameter int T_RP_PS   = 12000,
    parameter int T_RAS_PS  = 40000,
    parameter int T_RC_PS   = 57000,
    parameter int T_REFI_PS = 7800000,
    parameter int BURST_CLK = 4,
    localparam int BW       = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [BW-1:0]        cmd_bank,
    input  logic                 cmd_ap,
    input  logic                 temp_hi,
    output logic                 rsp_valid,
    output logic                 rsp_legal,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 ref_req
);
    localparam int RCD_CLK  = ps_to_clk(T_RCD_PS, CLK_PS);
    localparam int RP_CLK   = ps_to_clk(T_RP_PS, CLK_PS);
    localparam int RAS_CLK  = ps_to_clk(T_RAS_PS, CLK_PS);
    localparam int RC_CLK   = ps_to_clk(T_RC_PS, CLK_PS);
    localparam int REFI_CLK = ps_to_clk(T_REFI_PS, CLK_PS);

    cmd_op_e              op;
    logic [NUM_BANKS-1:0] act_ok, col_ok, pre_ok, idle_rdy;
    logic [NUM_BANKS-1:0] act_go, col_go, pre_go;
    logic                 legal, go, ref_go;

    // Select the verdict for the presented command.
    always_comb begin
        op = cmd_op_e'(cmd_op);
        case (op)
            OP_ACT:  legal = act_ok[cmd_bank];
            OP_RD,
            OP_WR:   legal = col_ok[cmd_bank];
            OP_PRE:  legal = pre_ok[cmd_bank];
            OP_REF:  legal = &idle_rdy;
            default: legal = 1'b0;
        endcase
        go     = cmd_valid && legal;
        ref_go = go && (op == OP_REF);
    end

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            // Route accepted commands to the addressed bank only.
            always_comb begin
                act_go[b] = go && (cmd_bank == BW'(b)) && (op == OP_ACT);
                col_go[b] = go && (cmd_bank == BW'(b)) && ((op == OP_RD) || (op == OP_WR));
                pre_go[b] = go && (cmd_bank == BW'(b)) && (op == OP_PRE);
            end

            dbt_bank #(
                .RCD_CLK  (RCD_CLK),
                .RP_CLK   (RP_CLK),
                .RAS_CLK  (RAS_CLK),
                .RC_CLK   (RC_CLK),
                .BURST_CLK(BURST_CLK)
            ) i_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .act_go  (act_go[b]),
                .col_go  (col_go[b]),
                .col_ap  (cmd_ap),
                .pre_go  (pre_go[b]),
                .act_ok  (act_ok[b]),
                .col_ok  (col_ok[b]),
                .pre_ok  (pre_ok[b]),
                .idle_rdy(idle_rdy[b]),
                .row_open(bank_open[b])
            );
        end
    endgenerate

    dbt_refresh #(.REFI_CLK(REFI_CLK)) i_refresh (
        .clk    (clk),
        .rst_n  (rst_n),
        .temp_hi(temp_hi),
        .ref_go (ref_go),
        .ref_req(ref_req)
    );

    // Register the verdict for each presented command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_legal <= 1'b0;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_legal <= go;
        end
    end

    // R4: every presented command gets exactly one verdict next cycle.
    a_r4_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);
    a_r4_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);
    // R9: an accepted command reaches at most one bank.
    a_r9_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_go | col_go | pre_go));

endmodule

// File: tb/test_dram_bank_timing_guard.sv
module test_dram_bank_timing_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [2:0] cmd_bank = 3'd0;
    logic       cmd_ap = 1'b0;
    logic       temp_hi = 1'b0;
    logic       rsp_valid, rsp_legal, ref_req;
    logic [7:0] bank_open;

    // Limits from R2 with the default parameters: ceil(ps / 3750).
    localparam int REFI = (7800000 + 3749) / 3750;   // 2080
    localparam int REFI_HOT = REFI / 2;              // 1040

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;
    bit exp_q[$];
    string tag_q[$];

    dram_bank_timing_guard i_dram_bank_timing_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .temp_hi(temp_hi),
        .rsp_valid(rsp_valid), .rsp_legal(rsp_legal),
        .bank_open(bank_open), .ref_req(ref_req)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    // Wait for the negedge after posedge number e.
    task automatic go_to(input int e);
        while (cyc < e) @(negedge clk);
    endtask

    // Present one command so it is sampled at posedge e; queue its verdict.
    task automatic issue(input int e, input int op, input int bank, input bit ap,
                         input bit exp, input string tag);
        go_to(e - 1);
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_bank  = 3'(bank);
        cmd_ap    = ap;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_ap    = 1'b0;
    endtask

    // Monitor: pop the expected verdict for every response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected response", 1, 0);
            end else begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, rsp_legal, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int b, k, k2;
        repeat (3) @(negedge clk);
        // R1: state while reset is applied
        chk("R1 rsp_valid in reset", rsp_valid, 0);
        chk("R1 bank_open in reset", bank_open, 0);
        chk("R1 ref_req in reset", ref_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp_valid after reset", rsp_valid, 0);
        chk("R1 bank_open after reset", bank_open, 0);
        b = cyc + 5;

        issue(b - 2, 1, 2, 0, 0, "R4 read to idle bank");
        chk("R8 idle read leaves bank closed", bank_open, 0);

        issue(b + 0,  0, 0, 0, 1, "R3 activate idle bank0");
        issue(b + 1,  1, 0, 0, 0, "R4 read one clock after activate");
        issue(b + 2,  3, 5, 0, 1, "R5 precharge on idle bank5");
        chk("R5 idle precharge no effect", bank_open, 8'h01);
        issue(b + 3,  1, 0, 0, 0, "R2 R4 read at rcd-1");
        issue(b + 4,  1, 0, 0, 1, "R2 R4 read at rcd");
        issue(b + 5,  3, 0, 0, 0, "R5 precharge before ras");
        issue(b + 6,  7, 0, 0, 0, "R8 unknown opcode");
        chk("R8 unknown opcode no effect", bank_open, 8'h01);
        issue(b + 10, 3, 0, 0, 0, "R2 R5 precharge at ras-1");
        issue(b + 11, 3, 0, 0, 1, "R2 R5 precharge at ras");
        chk("R5 precharge closes bank0", bank_open, 8'h00);
        issue(b + 12, 0, 0, 0, 0, "R3 activate during rp");
        issue(b + 15, 0, 0, 0, 0, "R2 R3 activate blocked by rc");
        issue(b + 16, 0, 0, 0, 1, "R2 R3 activate at rc");
        issue(b + 17, 0, 1, 0, 1, "R9 activate bank1 right after bank0");
        chk("R9 both banks open", bank_open, 8'h03);
        issue(b + 18, 0, 0, 0, 0, "R3 activate already open bank0");
        chk("R8 illegal activate keeps state", bank_open, 8'h03);
        issue(b + 19, 4, 0, 0, 0, "R10 refresh with rows open");
        chk("R8 refused refresh keeps request low", ref_req, 0);
        issue(b + 20, 1, 1, 0, 0, "R4 read bank1 at rcd-1");
        issue(b + 21, 2, 1, 1, 1, "R6 write with auto-precharge bank1");
        issue(b + 22, 1, 1, 0, 0, "R7 read during pending auto-precharge");
        go_to(b + 27);
        chk("R6 bank1 held open until ras", bank_open, 8'h03);
        go_to(b + 28);
        chk("R6 bank1 closed at ras", bank_open, 8'h01);

        issue(b + 36, 1, 0, 1, 1, "R6 read with auto-precharge bank0");
        issue(b + 37, 3, 0, 0, 0, "R7 precharge during pending auto-precharge");
        issue(b + 38, 2, 0, 0, 0, "R7 write during pending auto-precharge");
        go_to(b + 39);
        chk("R6 bank0 open before burst end", bank_open, 8'h01);
        go_to(b + 40);
        chk("R6 bank0 closed after burst", bank_open, 8'h00);
        issue(b + 43, 4, 0, 0, 0, "R10 refresh during precharge recovery");
        issue(b + 44, 4, 0, 0, 1, "R10 refresh all idle");
        k = b + 44;

        go_to(k + REFI - 1);
        chk("R11 request low at interval-1", ref_req, 0);
        go_to(k + REFI);
        chk("R11 request at interval", ref_req, 1);
        go_to(k + REFI + 120);
        chk("R11 request sticky", ref_req, 1);

        go_to(k + REFI + 200);
        temp_hi = 1'b1;
        k2 = k + REFI + 220;
        issue(k2, 4, 0, 0, 1, "R10 refresh accepted hot");
        chk("R10 refresh clears request", ref_req, 0);
        go_to(k2 + REFI_HOT - 1);
        chk("R12 hot request low at half-1", ref_req, 0);
        go_to(k2 + REFI_HOT);
        chk("R12 hot request at half interval", ref_req, 1);
        issue(k2 + REFI_HOT + 1, 0, 2, 0, 1, "R9 activate bank2");
        issue(k2 + REFI_HOT + 2, 4, 0, 0, 0, "R10 refresh with bank2 open");
        chk("R8 refused refresh keeps request", ref_req, 1);
        chk("R9 only bank2 open", bank_open, 8'h04);

        repeat (3) @(negedge clk);
        chk("R4 all verdicts received", exp_q.size(), 0);
        finish_run();
    end

endmodule